// File: doc/BRIEF.md
# Destructive-Read Memory Data Register

This block is the word-wide data register placed between a storage array whose reads destroy the stored word and the host that uses the words. During the read part of a memory cycle, sensed bits reach the register through set-only gates. A bit can be set only while the strobe window is open and the inhibit input is low. During the rewrite part of the cycle, every bit that holds a one drives its own restore (digit) enable, so the word just read goes back into the array.

The host starts every cycle by clearing the register. For a read, it then lets the sense path fill the register and takes the word from the read-back output. For a store, it loads its own word after the clear and raises inhibit for the whole cycle. The sensed word is then kept out, and the restore enables write the host's word in its place. Host loads are ORed into the held contents, in the same way as sense sets. If the clear is skipped, words merge bitwise.

The host write port is a pair of plain strobes with no handshake. The register accepts a load or a clear on any clock, so the port never applies back-pressure and the host needs no ready signal.

Top module: `mdr_top`

## Requirements
- R1: On a synchronous active-high reset the register holds all zeros, and all restore enables are low.
- R2: A bit is set in the clock where its sense input, the strobe window and a low inhibit are all present together. The sense input alone, or the strobe alone, leaves the bit unchanged.
- R3: While inhibit is high, no sense input sets any bit, whatever the strobe and sense values are.
- R4: The sense path never clears a bit. A one stays a one until a clear or a reset.
- R5: A host load ORs the host word into the held contents, so two loads with no clear between them leave the bitwise OR of both words.
- R6: A host clear sets the register to all zeros on the next clock. A clear takes priority over a load or a sense set in the same clock.
- R7: Each restore enable is the matching register bit ANDed with the digit-window input. All restore enables are zero while the window is low.
- R8: In a read cycle, the sequence clear, strobe with sense and no inhibit, then digit window restores exactly the word that was sensed.
- R9: In a store cycle, the sequence clear, host load, strobe with inhibit high, then digit window restores the host's word and not the sensed word.
- R10: With no load, no clear and no qualified sense set, the register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_clear | input | 1 | Clears the register on the next clock; takes priority |
| host_load | input | 1 | ORs host_word into the register on the next clock |
| host_word | input | WIDTH | Word supplied by the host |
| sense_bits | input | WIDTH | Sensed bit outputs from the array |
| strobe_win | input | 1 | Sense strobe window; qualifies sense_bits |
| inhibit | input | 1 | Blocks every sense set (store cycles) |
| digit_win | input | 1 | Rewrite window that gates the restore enables |
| rd_word | output | WIDTH | Register contents presented to the host |
| restore_en | output | WIDTH | Per-bit restore (digit) enables |

## Verification
The checker tests on every clock that bits never drop without a clear or reset, that a clear empties the register, that inhibit with no load freezes the contents, that an idle clock holds the value, and that no restore enable is active outside the window or for a zero bit. What only the bench scenarios can show is the exact value formed by each pairing of strobe, inhibit, sense pattern and preload, together with the OR merge of successive loads. The bench also runs full read and store cycles against a behavioural array. Those cycles show that the rewritten word is the sensed word in a read and the host's word in a store.

// File: rtl/mdr_pkg.sv
package mdr_pkg;
  localparam int unsigned MDR_WORD_W = 59;

  typedef enum logic [1:0] {
    UPD_HOLD  = 2'd0,
    UPD_MERGE = 2'd1,
    UPD_CLEAR = 2'd2
  } mdr_upd_e;
endpackage

// File: rtl/mdr_sense_gate.sv
module mdr_sense_gate #(
  parameter int unsigned WIDTH = mdr_pkg::MDR_WORD_W
) (
  input  logic [WIDTH-1:0] sense_bits,
  input  logic             strobe_win,
  input  logic             inhibit,
  output logic [WIDTH-1:0] set_mask
);
  logic qualify;
  assign qualify = strobe_win & ~inhibit;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign set_mask[i] = sense_bits[i] & qualify;
  end
endmodule

// File: rtl/mdr_word_reg.sv
module mdr_word_reg
  import mdr_pkg::*;
#(
  parameter int unsigned WIDTH = MDR_WORD_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_clear,
  input  logic             host_load,
  input  logic [WIDTH-1:0] host_word,
  input  logic [WIDTH-1:0] set_mask,
  output logic [WIDTH-1:0] q
);
  mdr_upd_e        upd;
  logic [WIDTH-1:0] merge_in;

  assign merge_in = set_mask | (host_load ? host_word : '0);

  always_comb begin
    if (host_clear)       upd = UPD_CLEAR;
    else if (|merge_in)   upd = UPD_MERGE;
    else                  upd = UPD_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      unique case (upd)
        UPD_CLEAR: q <= '0;
        UPD_MERGE: q <= q | merge_in;
        default:   q <= q;
      endcase
    end
  end
endmodule

// File: rtl/mdr_restore_drv.sv
module mdr_restore_drv #(
  parameter int unsigned WIDTH = mdr_pkg::MDR_WORD_W
) (
  input  logic [WIDTH-1:0] q,
  input  logic             digit_win,
  output logic [WIDTH-1:0] restore_en
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign restore_en[i] = q[i] & digit_win;
  end
endmodule

// File: rtl/mdr_top.sv
module mdr_top #(
  parameter int unsigned WIDTH = mdr_pkg::MDR_WORD_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_clear,
  input  logic             host_load,
  input  logic [WIDTH-1:0] host_word,
  input  logic [WIDTH-1:0] sense_bits,
  input  logic             strobe_win,
  input  logic             inhibit,
  input  logic             digit_win,
  output logic [WIDTH-1:0] rd_word,
  output logic [WIDTH-1:0] restore_en
);
  logic [WIDTH-1:0] set_mask;
  logic [WIDTH-1:0] q;

  mdr_sense_gate #(.WIDTH(WIDTH)) u_gate (
    .sense_bits(sense_bits),
    .strobe_win(strobe_win),
    .inhibit   (inhibit),
    .set_mask  (set_mask)
  );

  mdr_word_reg #(.WIDTH(WIDTH)) u_reg (
    .clk       (clk),
    .rst       (rst),
    .host_clear(host_clear),
    .host_load (host_load),
    .host_word (host_word),
    .set_mask  (set_mask),
    .q         (q)
  );

  mdr_restore_drv #(.WIDTH(WIDTH)) u_drv (
    .q         (q),
    .digit_win (digit_win),
    .restore_en(restore_en)
  );

  assign rd_word = q;
endmodule

// File: rtl/mdr_checker.sv
module mdr_checker #(
  parameter int unsigned WIDTH = mdr_pkg::MDR_WORD_W
) (
  input logic             clk,
  input logic             rst,
  input logic             host_clear,
  input logic             host_load,
  input logic [WIDTH-1:0] sense_bits,
  input logic             strobe_win,
  input logic             inhibit,
  input logic             digit_win,
  input logic [WIDTH-1:0] rd_word,
  input logic [WIDTH-1:0] restore_en
);
  logic started;
  always_ff @(posedge clk) begin
    if (rst) started <= 1'b1;
  end

  p_reset_zero_r1: assert property (@(posedge clk) rst |=> rd_word == '0);

  p_no_drop_r4: assert property (@(posedge clk) disable iff (rst || !started)
    !host_clear |=> ((rd_word & $past(rd_word)) == $past(rd_word)));

  p_inhibit_freeze_r3: assert property (@(posedge clk) disable iff (rst || !started)
    (inhibit && !host_load && !host_clear) |=> $stable(rd_word));

  p_clear_r6: assert property (@(posedge clk) disable iff (rst || !started)
    host_clear |=> rd_word == '0);

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst || !started)
    (!host_clear && !host_load && (!strobe_win || sense_bits == '0)) |=> $stable(rd_word));

  p_restore_window_r7: assert property (@(posedge clk) disable iff (rst || !started)
    !digit_win |-> restore_en == '0);

  p_restore_subset_r7: assert property (@(posedge clk) disable iff (rst || !started)
    (restore_en & ~rd_word) == '0);
endmodule

bind mdr_top mdr_checker #(.WIDTH(WIDTH)) u_mdr_checker (
  .clk       (clk),
  .rst       (rst),
  .host_clear(host_clear),
  .host_load (host_load),
  .sense_bits(sense_bits),
  .strobe_win(strobe_win),
  .inhibit   (inhibit),
  .digit_win (digit_win),
  .rd_word   (rd_word),
  .restore_en(restore_en)
);

// File: tb/mdr_top_tb.sv
module mdr_top_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst;
  logic         host_clear, host_load, strobe_win, inhibit, digit_win;
  logic [W-1:0] host_word, sense_bits;
  logic [W-1:0] rd_word, restore_en;

  int n_vec = 0;
  int n_bad = 0;
  logic [W-1:0] arr [4];

  always #2.5 clk = ~clk;

  mdr_top #(.WIDTH(W)) u_dut (
    .clk(clk), .rst(rst), .host_clear(host_clear), .host_load(host_load),
    .host_word(host_word), .sense_bits(sense_bits), .strobe_win(strobe_win),
    .inhibit(inhibit), .digit_win(digit_win), .rd_word(rd_word),
    .restore_en(restore_en)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    host_clear = 0; host_load = 0; strobe_win = 0; inhibit = 0; digit_win = 0;
    host_word = '0; sense_bits = '0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic do_clear();
    host_clear = 1; step();
  endtask

  task automatic do_load(input logic [W-1:0] w);
    host_load = 1; host_word = w; step();
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    idle();
    rst = 1;
    @(negedge clk);
    host_load = 1; host_word = 8'hFF;
    step();
    step();
    chk("R1 reset word", rd_word, '0);
    digit_win = 1; #1;
    chk("R1 reset restore", restore_en, '0);
    rst = 0;
    idle();
    @(negedge clk);

    // R2 R3 R4: sweep strobe, inhibit, sense pattern and preload
    for (int s = 0; s < 2; s++) begin
      for (int h = 0; h < 2; h++) begin
        for (int p = 0; p < 16; p++) begin
          for (int v = 0; v < 16; v++) begin
            logic [W-1:0] pre, sen, exp;
            pre = W'(p * 17 + 3);
            sen = W'(v * 29 + 5);
            exp = pre | ((s == 1 && h == 0) ? sen : '0);
            do_clear();
            do_load(pre);
            strobe_win = s[0]; inhibit = h[0]; sense_bits = sen;
            step();
            chk(h ? "R3 inhibit sweep" : "R2 gate sweep", rd_word, exp);
            chk("R4 no drop", rd_word & pre, pre);
          end
        end
      end
    end

    // R5 OR merge of loads
    for (int a = 0; a < 16; a++) begin
      logic [W-1:0] wa, wb;
      wa = W'(a * 37 + 1);
      wb = W'(a * 11 + 64);
      do_clear();
      do_load(wa);
      do_load(wb);
      chk("R5 load merge", rd_word, wa | wb);
    end

    // R6 clear priority
    do_load(8'hA5);
    host_clear = 1; host_load = 1; host_word = 8'h3C;
    strobe_win = 1; sense_bits = 8'hFF;
    step();
    chk("R6 clear priority", rd_word, '0);

    // R10 hold
    do_load(8'h69);
    sense_bits = 8'hFF; step();
    strobe_win = 1; step();
    step();
    chk("R10 hold", rd_word, 8'h69);

    // R7 restore window
    digit_win = 0; #1;
    chk("R7 window low", restore_en, '0);
    digit_win = 1; #1;
    chk("R7 window high", restore_en, 8'h69);
    idle();

    // R8 R9 full cycles with behavioural array
    for (int i = 0; i < 4; i++) arr[i] = W'(i * 53 + 7);
    for (int i = 0; i < 4; i++) begin
      logic [W-1:0] old, nw;
      old = arr[i];
      do_clear();
      strobe_win = 1; sense_bits = arr[i]; arr[i] = '0; step();
      digit_win = 1; #1;
      chk("R8 read word", rd_word, old);
      arr[i] = restore_en;
      step();
      chk("R8 array restored", arr[i], old);

      nw = ~old;
      do_clear();
      do_load(nw);
      inhibit = 1; strobe_win = 1; sense_bits = arr[i]; arr[i] = '0; step();
      inhibit = 1; digit_win = 1; #1;
      arr[i] = restore_en;
      step();
      chk("R9 store word", arr[i], nw);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule